// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands over several clock cycles using radix-2 Booth recoding. A one-cycle pulse on `start` captures the multiplicand and the multiplier. The multiplier goes into the low half of a working product register. The upper half is an accumulator that starts at zero, and a guard bit to the right of the least significant product bit starts at zero.

On each step the block looks at two bits: the current low product bit and the guard bit. That pair decides the accumulator operation:

| Current bit | Guard bit | Operation on the accumulator |
|---|---|---|
| 1 | 0 | subtract the multiplicand (a run of ones starts) |
| 0 | 1 | add the multiplicand (a run of ones ends) |
| 0 | 0 | no arithmetic |
| 1 | 1 | no arithmetic |

Addition and subtraction share one adder. Subtraction feeds the inverted multiplicand into the adder with a carry-in of one. After the operation, the accumulator, the low half and the guard bit shift right together as one arithmetic value, so the sign bit is kept. After `W` steps, `done` rises and the signed product of width `2*W` stays on `product_o` until the next accepted `start`.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `done_o` is 0 and `product_o` is 0.
- R2: A `start` that is high at a rising edge while no computation is running captures `mcand_i` and `mplier_i`, and `done_o` is 0 after that edge.
- R3: `done_o` rises at exactly the `W`-th rising edge after the edge that accepted `start`, that is after exactly `W` recoding steps.
- R4: When `done_o` is 1, `product_o` equals the signed product of the two captured operands, interpreted as two's complement, for arbitrary operand values.
- R5: Each step uses the pair (current low product bit, guard bit) as shown in the table above: (1,0) subtracts the multiplicand, (0,1) adds it, and (0,0) and (1,1) leave the accumulator unchanged. Multipliers made of alternating runs of ones therefore give exact products.
- R6: When both operands are at their most negative value (only the sign bit set), the result is exactly 2^(2W-2), with no overflow of the accumulator.
- R7: A zero multiplicand or a zero multiplier gives a product of 0. A multiplier of all ones (-1) gives the negated multiplicand, including when the multiplicand is at its most negative value.
- R8: A `start` pulse that arrives while a computation is running is ignored. The running result and its completion time do not change.
- R9: Once `done_o` is 1, `done_o` and `product_o` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication; accepted only when no computation is running |
| mcand_i | input | W | Signed multiplicand |
| mplier_i | input | W | Signed multiplier |
| done_o | output | 1 | High while a finished product is held |
| product_o | output | 2*W | Signed product; valid while `done_o` is high |

## Verification
The assertions assume that `start` is a clean synchronous level with no X values. They also assume that the operands only matter at the edge that accepts `start`. The properties on holding the result and on ignoring a late `start` are written so that they still hold when `start` is pulsed during a computation. The bench changes its inputs only on falling edges. It keeps `start` high for exactly one cycle, except in the directed case that pulses it on purpose during a computation. Random operands come from `$urandom` with a fixed seed and are mixed with directed extremes: most-negative values, zero, minus one and alternating bit patterns.

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  localparam int CW = $clog2(W) + 1;

  logic [W:0]    acc;
  logic [W-1:0]  low;
  logic          guard;
  logic [W-1:0]  mcand_q;
  logic [CW-1:0] step_cnt;
  logic          busy;

  logic [1:0] pair;
  logic       do_op, do_sub;
  logic [W:0] mc_ext, operand, acc_next;

  assign pair     = {low[0], guard};
  assign do_op    = pair[1] ^ pair[0];
  assign do_sub   = pair[1];
  assign mc_ext   = {mcand_q[W-1], mcand_q};
  assign operand  = do_sub ? ~mc_ext : mc_ext;
  assign acc_next = do_op ? (acc + operand + {{W{1'b0}}, do_sub}) : acc;

  wire accept = start && !busy;
  wire last   = busy && (step_cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      low      <= '0;
      guard    <= 1'b0;
      mcand_q  <= '0;
      step_cnt <= '0;
      busy     <= 1'b0;
      done_o   <= 1'b0;
    end else if (accept) begin
      acc      <= '0;
      low      <= mplier_i;
      guard    <= 1'b0;
      mcand_q  <= mcand_i;
      step_cnt <= '0;
      busy     <= 1'b1;
      done_o   <= 1'b0;
    end else if (busy) begin
      acc      <= {acc_next[W], acc_next[W:1]};
      low      <= {acc_next[0], low[W-1:1]};
      guard    <= low[0];
      step_cnt <= step_cnt + 1'b1;
      if (last) begin
        busy   <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  assign product_o = {acc[W-1:0], low};

  assert_done_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !done_o);

  assert_no_done_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy));

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_cnt < CW'(W)));

  assert_finish_sets_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_o);

  assert_late_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mcand_q));

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start) |=> (done_o && $stable(product_o)));

  assert_skip_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && (low[0] == guard)) |=> (low[W-1] == $past(acc[0])) && (acc[W-1:0] == $past(acc[W:1])));
endmodule

// File: tb/booth_seq_mult_tb_top.sv
module booth_seq_mult_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic done;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  booth_seq_mult #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand_i(mcand), .mplier_i(mplier),
    .done_o(done), .product_o(product)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] sa, sb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req,
                        input bit late_start);
    int n;
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    check("R2 done low after start", {63'd0, done}, 64'd0);
    n = 0;
    while (!done && n < W + 10) begin
      if (late_start && n == 5) begin
        start = 1'b1; mcand = ~a; mplier = b + 1;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    check("R3 latency", 64'(n), 64'(W));
    check(req, product, ref_mul(a, b));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 done in reset", {63'd0, done}, 64'd0);
    check("R1 product in reset", product, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after release", {63'd0, done}, 64'd0);

    run_op(32'd6, 32'd3, "R4 small", 1'b0);
    run_op(32'h8000_0000, 32'h8000_0000, "R6 both most negative", 1'b0);
    check("R6 exact value", product, 64'h4000_0000_0000_0000);
    run_op(32'd0, 32'h1234_5678, "R7 zero multiplicand", 1'b0);
    run_op(32'h8765_4321, 32'd0, "R7 zero multiplier", 1'b0);
    run_op(32'd12345, 32'hFFFF_FFFF, "R7 all-ones multiplier", 1'b0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, "R7 most negative times -1", 1'b0);
    run_op(32'hFFFF_FFFF, 32'h8000_0000, "R6 -1 times most negative", 1'b0);
    run_op(32'd7, 32'h5555_5555, "R5 alternating 01", 1'b0);
    run_op(32'hFFFF_FFF9, 32'hAAAA_AAAA, "R5 alternating 10", 1'b0);
    run_op(32'd113, 32'h0F0F_F0F0, "R5 runs of ones", 1'b0);
    run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 max positive", 1'b0);
    run_op(32'h1357_9BDF, 32'hCAFE_0001, "R8 late start ignored", 1'b1);

    begin
      logic [2*W-1:0] held;
      held = product;
      repeat (6) @(negedge clk);
      check("R9 done held", {63'd0, done}, 64'd1);
      check("R9 product held", product, held);
    end

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = $urandom();
      b = $urandom();
      if (i % 8 == 3) a = 32'h8000_0000;
      if (i % 8 == 6) b = {W{1'b1}};
      run_op(a, b, "R4 random", 1'b0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule